// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between a clock generator and the clock output pins of a board-level clock source. It takes an internal CPU clock, an internal PCI clock and a free-running PCI-rate reference clock. It passes them to a set of gated outputs: a CPU group, an SDRAM group that shares the CPU clock, a PCI group, and one free-running PCI output. Each output has its own enable bit from the serial configuration path. The CPU group and the PCI group also answer to an active-low stop pin. A strap input decides whether those stop pins are live at all.

Run requests and enable bits are captured together on the rising edge of the reference clock. Each output then changes state only on the next falling edge of its own clock. A stopped output therefore sits low, and no high phase is ever cut short when an output stops or resumes. The clocks themselves come from outside the block.

Top module: `clk_stop_gate`

## Requirements
- R1: An output runs only while its enable bit is 1 and its group is allowed to run. The group is allowed to run when its stop pin is high or the stop pins are disabled. The CPU and SDRAM outputs use `stop_cpu_n`, and the PCI outputs use `stop_pci_n`.
- R2: While `mode_strap` is 1, both stop pins are ignored and every output follows its enable bit alone. The stop pins are live only while `mode_strap` is 0.
- R3: The stop pins, the strap and all enable bits take effect only through their values at a rising edge of `clk_ref`. A change that is undone before the next rising edge has no effect on any output.
- R4: The run state of a gated output changes only at a falling edge of that output's own clock. Every high phase that reaches an output lasts the whole high phase of the source clock.
- R5: A stopped output is held at 0. After a resume, its first high phase is a full one.
- R6: After the `clk_ref` rising edge that captures a request, a CPU or SDRAM output switches at the next falling edge of `clk_cpu`, and a PCI output switches at the next falling edge of `clk_pci`. Both switch within one cycle of their own clock.
- R7: The free-running output `free_clk_o` is `clk_ref` gated only by `en_free`, switched on the falling edge of `clk_ref`. Neither stop pin affects it.
- R8: The SDRAM outputs stop and resume together with the CPU group under `stop_cpu_n`, each still subject to its own bit of `en_sdram`.
- R9: While `rst_n` is low, all outputs are 0. After `rst_n` rises, the first request capture happens on the third rising edge of `clk_ref`, so outputs stay low until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Internal CPU-rate clock, source of the CPU and SDRAM outputs |
| clk_pci | input | 1 | Internal PCI-rate clock, source of the PCI outputs |
| clk_ref | input | 1 | Free-running PCI-rate reference clock; request sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on `clk_ref` |
| mode_strap | input | 1 | 1 = stop pins ignored, 0 = stop pins live |
| stop_cpu_n | input | 1 | Active-low stop request for the CPU and SDRAM groups |
| stop_pci_n | input | 1 | Active-low stop request for the PCI group |
| en_cpu | input | N_CPU | Per-output enable bits, CPU group |
| en_sdram | input | N_SDRAM | Per-output enable bits, SDRAM group |
| en_pci | input | N_PCI | Per-output enable bits, PCI group |
| en_free | input | 1 | Enable bit of the free-running output |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| sdram_clk_o | output | N_SDRAM | Gated SDRAM clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| free_clk_o | output | 1 | Gated free-running PCI clock |

## Verification
The latency properties assume a fixed clock relationship. `clk_pci` has the same phase as `clk_ref`, and both `clk_cpu` and `clk_pci` have a falling edge after every `clk_ref` rise and before the next one. Under that assumption, a gate state sampled at a reference rise already reflects the request captured one reference cycle earlier. The stop pins and enable bits are also assumed to change away from the reference rising edge, as they would when driven from the reference domain. The stimulus meets both assumptions: it derives `clk_ref` and `clk_pci` by dividing the 100 MHz CPU clock by two, and it changes every input 3 ns after a reference rise or at other instants that fall on no clock edge.

// File: rtl/csg_pkg.sv
package csg_pkg;

  // Permission for each stoppable group to run, after the strap has been applied.
  typedef struct packed {
    logic cpu_ok;
    logic pci_ok;
  } grp_allow_t;

  // A group may run when its pin is high or when the pins are not live.
  function automatic grp_allow_t decode_allow(input logic pins_live,
                                              input logic cpu_stop_n,
                                              input logic pci_stop_n);
    grp_allow_t a;
    a.cpu_ok = ~pins_live | cpu_stop_n;
    a.pci_ok = ~pins_live | pci_stop_n;
    return a;
  endfunction

endpackage

// File: rtl/csg_rst_sync.sv
module csg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      sh_d[i] = sh_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/csg_req_sampler.sv
module csg_req_sampler
  import csg_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int N_SDRAM = 12,
  parameter int N_PCI   = 6
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               mode_strap,
  input  logic               stop_cpu_n,
  input  logic               stop_pci_n,
  input  logic [N_CPU-1:0]   en_cpu,
  input  logic [N_SDRAM-1:0] en_sdram,
  input  logic [N_PCI-1:0]   en_pci,
  input  logic               en_free,
  output logic [N_CPU-1:0]   req_cpu,
  output logic [N_SDRAM-1:0] req_sdram,
  output logic [N_PCI-1:0]   req_pci,
  output logic               req_free
);

  grp_allow_t         allow;
  logic [N_CPU-1:0]   cpu_d;
  logic [N_SDRAM-1:0] sdram_d;
  logic [N_PCI-1:0]   pci_d;
  logic               free_d;

  // Next state: enable bit AND group permission (free output ignores the pins).
  always_comb begin
    allow   = decode_allow(~mode_strap, stop_cpu_n, stop_pci_n);
    cpu_d   = en_cpu   & {N_CPU{allow.cpu_ok}};
    sdram_d = en_sdram & {N_SDRAM{allow.cpu_ok}};
    pci_d   = en_pci   & {N_PCI{allow.pci_ok}};
    free_d  = en_free;
  end

  // One capture point for every request, on the reference clock rise.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      req_cpu   <= '0;
      req_sdram <= '0;
      req_pci   <= '0;
      req_free  <= 1'b0;
    end else begin
      req_cpu   <= cpu_d;
      req_sdram <= sdram_d;
      req_pci   <= pci_d;
      req_free  <= free_d;
    end
  end

endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_gated,
  output logic gate_q
);

  logic en_d;
  logic en_q;

  always_comb en_d = run_req;

  // The enable moves only while clk is low, so a high phase is never cut.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign clk_gated = clk & en_q;
  assign gate_q    = en_q;

endmodule

// File: rtl/csg_gate_bank.sv
module csg_gate_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] run_req,
  output logic [WIDTH-1:0] clk_out,
  output logic [WIDTH-1:0] gate_q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    csg_gate_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_req   (run_req[g]),
      .clk_gated (clk_out[g]),
      .gate_q    (gate_q[g])
    );
  end

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_CPU       = 4,
  parameter int N_SDRAM     = 12,
  parameter int N_PCI       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_cpu,
  input  logic               clk_pci,
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               mode_strap,
  input  logic               stop_cpu_n,
  input  logic               stop_pci_n,
  input  logic [N_CPU-1:0]   en_cpu,
  input  logic [N_SDRAM-1:0] en_sdram,
  input  logic [N_PCI-1:0]   en_pci,
  input  logic               en_free,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic               free_clk_o
);

  localparam int N_FREE = 1;

  logic               rst_sync_n;
  logic [N_CPU-1:0]   req_cpu;
  logic [N_SDRAM-1:0] req_sdram;
  logic [N_PCI-1:0]   req_pci;
  logic               req_free;
  logic [N_FREE-1:0]  req_free_v;
  logic [N_CPU-1:0]   gate_cpu;
  logic [N_SDRAM-1:0] gate_sdram;
  logic [N_PCI-1:0]   gate_pci;
  logic [N_FREE-1:0]  gate_free_v;
  logic [N_FREE-1:0]  free_out_v;

  csg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk_ref),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  csg_req_sampler #(
    .N_CPU   (N_CPU),
    .N_SDRAM (N_SDRAM),
    .N_PCI   (N_PCI)
  ) u_sampler (
    .clk_ref    (clk_ref),
    .rst_n      (rst_sync_n),
    .mode_strap (mode_strap),
    .stop_cpu_n (stop_cpu_n),
    .stop_pci_n (stop_pci_n),
    .en_cpu     (en_cpu),
    .en_sdram   (en_sdram),
    .en_pci     (en_pci),
    .en_free    (en_free),
    .req_cpu    (req_cpu),
    .req_sdram  (req_sdram),
    .req_pci    (req_pci),
    .req_free   (req_free)
  );

  assign req_free_v = req_free;

  csg_gate_bank #(.WIDTH(N_CPU)) u_cpu_bank (
    .clk     (clk_cpu),
    .rst_n   (rst_sync_n),
    .run_req (req_cpu),
    .clk_out (cpu_clk_o),
    .gate_q  (gate_cpu)
  );

  csg_gate_bank #(.WIDTH(N_SDRAM)) u_sdram_bank (
    .clk     (clk_cpu),
    .rst_n   (rst_sync_n),
    .run_req (req_sdram),
    .clk_out (sdram_clk_o),
    .gate_q  (gate_sdram)
  );

  csg_gate_bank #(.WIDTH(N_PCI)) u_pci_bank (
    .clk     (clk_pci),
    .rst_n   (rst_sync_n),
    .run_req (req_pci),
    .clk_out (pci_clk_o),
    .gate_q  (gate_pci)
  );

  csg_gate_bank #(.WIDTH(N_FREE)) u_free_bank (
    .clk     (clk_ref),
    .rst_n   (rst_sync_n),
    .run_req (req_free_v),
    .clk_out (free_out_v),
    .gate_q  (gate_free_v)
  );

  assign free_clk_o = free_out_v[0];

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int N_CPU   = 4,
  parameter int N_SDRAM = 12,
  parameter int N_PCI   = 6
) (
  input logic               clk_cpu,
  input logic               clk_pci,
  input logic               clk_ref,
  input logic               rst_s,
  input logic               mode_strap,
  input logic               stop_cpu_n,
  input logic               stop_pci_n,
  input logic [N_CPU-1:0]   en_cpu,
  input logic               en_free,
  input logic [N_CPU-1:0]   req_cpu,
  input logic [N_SDRAM-1:0] req_sdram,
  input logic [N_PCI-1:0]   req_pci,
  input logic               req_free,
  input logic [N_CPU-1:0]   gate_cpu,
  input logic [N_SDRAM-1:0] gate_sdram,
  input logic [N_PCI-1:0]   gate_pci,
  input logic               gate_free
);

  // Gate state seen at each rising edge, compared at the following fall.
  logic [N_CPU-1:0]   cpu_at_rise;
  logic [N_SDRAM-1:0] sd_at_rise;
  logic [N_PCI-1:0]   pci_at_rise;

  always_ff @(posedge clk_cpu or negedge rst_s) begin
    if (!rst_s) begin
      cpu_at_rise <= '0;
      sd_at_rise  <= '0;
    end else begin
      cpu_at_rise <= gate_cpu;
      sd_at_rise  <= gate_sdram;
    end
  end

  always_ff @(posedge clk_pci or negedge rst_s) begin
    if (!rst_s) begin
      pci_at_rise <= '0;
    end else begin
      pci_at_rise <= gate_pci;
    end
  end

  AST_STRAP_MASKS_PINS: assert property (@(posedge clk_ref) disable iff (!rst_s)
    mode_strap |=> (req_cpu == $past(en_cpu))); // R2

  AST_PCI_PIN_STOPS: assert property (@(posedge clk_ref) disable iff (!rst_s)
    (!mode_strap && !stop_pci_n) |=> (req_pci == '0)); // R1

  AST_CPU_PIN_STOPS_SDRAM: assert property (@(posedge clk_ref) disable iff (!rst_s)
    (!mode_strap && !stop_cpu_n) |=> (req_sdram == '0 && req_cpu == '0)); // R8

  AST_FREE_RUNS_ON_ENABLE: assert property (@(posedge clk_ref) disable iff (!rst_s)
    en_free |=> req_free); // R7

  AST_FREE_STOPS_ON_ENABLE: assert property (@(posedge clk_ref) disable iff (!rst_s)
    !en_free |=> !req_free); // R7

  AST_CPU_SWITCH_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_s)
    gate_cpu == req_cpu); // R6

  AST_SDRAM_SWITCH_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_s)
    gate_sdram == req_sdram); // R6

  AST_PCI_SWITCH_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_s)
    gate_pci == req_pci); // R6

  AST_FREE_SWITCH_BOUND: assert property (@(posedge clk_ref) disable iff (!rst_s)
    gate_free == req_free); // R7

  AST_CPU_HIGH_INTACT: assert property (@(negedge clk_cpu) disable iff (!rst_s)
    gate_cpu == cpu_at_rise); // R4

  AST_SDRAM_HIGH_INTACT: assert property (@(negedge clk_cpu) disable iff (!rst_s)
    gate_sdram == sd_at_rise); // R4

  AST_PCI_HIGH_INTACT: assert property (@(negedge clk_pci) disable iff (!rst_s)
    gate_pci == pci_at_rise); // R4

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .N_CPU   (N_CPU),
  .N_SDRAM (N_SDRAM),
  .N_PCI   (N_PCI)
) u_chk (
  .clk_cpu    (clk_cpu),
  .clk_pci    (clk_pci),
  .clk_ref    (clk_ref),
  .rst_s      (rst_sync_n),
  .mode_strap (mode_strap),
  .stop_cpu_n (stop_cpu_n),
  .stop_pci_n (stop_pci_n),
  .en_cpu     (en_cpu),
  .en_free    (en_free),
  .req_cpu    (req_cpu),
  .req_sdram  (req_sdram),
  .req_pci    (req_pci),
  .req_free   (req_free),
  .gate_cpu   (gate_cpu),
  .gate_sdram (gate_sdram),
  .gate_pci   (gate_pci),
  .gate_free  (gate_free_v[0])
);

// File: tb/clk_stop_gate_bench.sv
module clk_stop_gate_bench;

  localparam int N_CPU   = 4;
  localparam int N_SDRAM = 12;
  localparam int N_PCI   = 6;

  logic               clk_cpu;
  logic               clk_pci;
  logic               clk_ref;
  logic               rst_n;
  logic               mode_strap;
  logic               stop_cpu_n;
  logic               stop_pci_n;
  logic [N_CPU-1:0]   en_cpu;
  logic [N_SDRAM-1:0] en_sdram;
  logic [N_PCI-1:0]   en_pci;
  logic               en_free;
  logic [N_CPU-1:0]   cpu_clk_o;
  logic [N_SDRAM-1:0] sdram_clk_o;
  logic [N_PCI-1:0]   pci_clk_o;
  logic               free_clk_o;

  int    checks;
  int    errors;
  bit    done;
  string phase_tag;

  // Reference model state.
  int                 ref_edges;
  logic [N_CPU-1:0]   m_req_cpu,   m_g_cpu;
  logic [N_SDRAM-1:0] m_req_sd,    m_g_sd;
  logic [N_PCI-1:0]   m_req_pci,   m_g_pci;
  logic               m_req_free,  m_g_free;

  clk_stop_gate u_clk_stop_gate (
    .clk_cpu     (clk_cpu),
    .clk_pci     (clk_pci),
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .mode_strap  (mode_strap),
    .stop_cpu_n  (stop_cpu_n),
    .stop_pci_n  (stop_pci_n),
    .en_cpu      (en_cpu),
    .en_sdram    (en_sdram),
    .en_pci      (en_pci),
    .en_free     (en_free),
    .cpu_clk_o   (cpu_clk_o),
    .sdram_clk_o (sdram_clk_o),
    .pci_clk_o   (pci_clk_o),
    .free_clk_o  (free_clk_o)
  );

  // 100 MHz CPU clock; reference and PCI clocks at half rate, in phase.
  initial begin
    clk_cpu = 1'b0;
    clk_ref = 1'b0;
    clk_pci = 1'b0;
    forever #5 clk_cpu = ~clk_cpu;
  end

  always @(posedge clk_cpu) begin
    clk_ref <= ~clk_ref;
    clk_pci <= ~clk_pci;
  end

  // Model: capture on reference rise, third rise after reset release first (R9).
  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ref_edges  = 0;
      m_req_cpu  = '0;
      m_req_sd   = '0;
      m_req_pci  = '0;
      m_req_free = 1'b0;
    end else begin
      if (ref_edges >= 2) begin
        m_req_cpu  = (mode_strap || stop_cpu_n) ? en_cpu   : '0;
        m_req_sd   = (mode_strap || stop_cpu_n) ? en_sdram : '0;
        m_req_pci  = (mode_strap || stop_pci_n) ? en_pci   : '0;
        m_req_free = en_free;
      end
      if (ref_edges < 2) ref_edges = ref_edges + 1;
    end
  end

  always @(negedge clk_cpu or negedge rst_n) begin
    if (!rst_n) begin
      m_g_cpu = '0;
      m_g_sd  = '0;
    end else begin
      m_g_cpu = m_req_cpu;
      m_g_sd  = m_req_sd;
    end
  end

  always @(negedge clk_pci or negedge rst_n) begin
    if (!rst_n) m_g_pci = '0;
    else        m_g_pci = m_req_pci;
  end

  always @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) m_g_free = 1'b0;
    else        m_g_free = m_req_free;
  end

  task automatic chk(input string grp, input string pos,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s t=%0t actual=%h expected=%h",
               phase_tag, pos, grp, $time, act, exp);
    end
  endtask

  task automatic compare_all(input string pos);
    chk("cpu",   pos, 32'(cpu_clk_o),   32'({N_CPU{clk_cpu}} & m_g_cpu));
    chk("sdram", pos, 32'(sdram_clk_o), 32'({N_SDRAM{clk_cpu}} & m_g_sd));
    chk("pci",   pos, 32'(pci_clk_o),   32'({N_PCI{clk_pci}} & m_g_pci));
    chk("free",  pos, 32'(free_clk_o),  32'(clk_ref & m_g_free));
  endtask

  // Early and late in each high phase (R4: no cut pulse), mid low phase (R5).
  always @(posedge clk_cpu) begin
    if (!done) begin
      #1 compare_all("R4");
      #3 compare_all("R4");
    end
  end

  always @(negedge clk_cpu) begin
    if (!done) begin
      #2 compare_all("R5");
    end
  end

  task automatic ref_steps(input int n);
    repeat (n) @(posedge clk_ref);
    #3;
  endtask

  task automatic set_all_en(input logic v);
    en_cpu   = {N_CPU{v}};
    en_sdram = {N_SDRAM{v}};
    en_pci   = {N_PCI{v}};
    en_free  = v;
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    done       = 1'b0;
    phase_tag  = "R9";
    ref_edges  = 0;
    m_req_cpu  = '0; m_g_cpu  = '0;
    m_req_sd   = '0; m_g_sd   = '0;
    m_req_pci  = '0; m_g_pci  = '0;
    m_req_free = 1'b0; m_g_free = 1'b0;
    rst_n      = 1'b1;
    mode_strap = 1'b0;
    stop_cpu_n = 1'b1;
    stop_pci_n = 1'b1;
    set_all_en(1'b1);
    #1 rst_n = 1'b0;

    // R9: everything low in reset even with every enable set.
    ref_steps(4);
    chk("cpu",   "R9", 32'(cpu_clk_o),   32'd0);
    chk("sdram", "R9", 32'(sdram_clk_o), 32'd0);
    chk("pci",   "R9", 32'(pci_clk_o),   32'd0);
    chk("free",  "R9", 32'(free_clk_o),  32'd0);
    rst_n = 1'b1;
    ref_steps(1);
    #5 chk("cpu", "R9", 32'(cpu_clk_o), 32'd0);

    phase_tag = "R1";
    ref_steps(10);

    // CPU stop: CPU and SDRAM park, PCI and free keep running.
    phase_tag = "R8";
    stop_cpu_n = 1'b0;
    ref_steps(8);
    phase_tag = "R6";
    stop_cpu_n = 1'b1;
    ref_steps(6);

    // PCI stop: free-running output unaffected.
    phase_tag = "R7";
    stop_pci_n = 1'b0;
    ref_steps(8);
    stop_pci_n = 1'b1;
    ref_steps(4);

    phase_tag = "R1";
    stop_cpu_n = 1'b0;
    stop_pci_n = 1'b0;
    ref_steps(6);
    stop_cpu_n = 1'b1;
    stop_pci_n = 1'b1;
    en_cpu   = 4'b0101;
    en_sdram = 12'ha5c;
    en_pci   = 6'b100110;
    en_free  = 1'b0;
    ref_steps(6);
    set_all_en(1'b1);
    ref_steps(3);

    // R3: pulses that never meet a reference rise change nothing.
    phase_tag = "R3";
    for (int k = 0; k < 4; k++) begin
      en_cpu = '0;
      stop_pci_n = 1'b0;
      #4;
      en_cpu = '1;
      #5;
      stop_pci_n = 1'b1;
      ref_steps(1);
    end
    ref_steps(2);

    // R2: with the strap set the pins are dead.
    phase_tag = "R2";
    mode_strap = 1'b1;
    ref_steps(2);
    stop_cpu_n = 1'b0;
    stop_pci_n = 1'b0;
    ref_steps(8);
    en_pci = 6'b010101;
    ref_steps(4);
    mode_strap = 1'b0;
    ref_steps(4);
    stop_cpu_n = 1'b1;
    stop_pci_n = 1'b1;
    set_all_en(1'b1);
    ref_steps(4);

    // R5: irregular stop/resume and enable traffic.
    phase_tag = "R5";
    for (int k = 0; k < 150; k++) begin
      stop_cpu_n = 1'($urandom_range(0, 1));
      stop_pci_n = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) mode_strap = ~mode_strap;
      if ($urandom_range(0, 3) == 0) begin
        en_cpu   = N_CPU'($urandom);
        en_sdram = N_SDRAM'($urandom);
        en_pci   = N_PCI'($urandom);
        en_free  = 1'($urandom);
      end
      ref_steps(1 + $urandom_range(0, 2));
    end

    done = 1'b1;
    #20;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL %s watchdog actual=running expected=finished", phase_tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule